// File: doc/BRIEF.md
# Single-Wire Ratio-Coded Command Receiver

This block listens to one wire on which a host sends commands. It codes every bit in the ratio between how long the line stays low and how long it stays high. A bit period runs from one falling edge of the line to the next. Because the decision depends only on the ratio of the two durations, the receiver accepts a very wide range of bit rates without being told the rate in advance.

A command is a 24-bit word sent least significant bit first. The top byte (word bits 23..16) is an address that must read 0x8F. The low half carries a 9-bit brightness code, a request-for-acknowledge flag and reserved bits. An accepted word updates the brightness output and raises a one-cycle valid strobe. When the word also sets the acknowledge flag, the block pulls the shared wire low for a fixed time after a fixed delay. It does this through an open-drain enable output.

The line input is synchronized inside the block through a two-flop chain. An ambiguous bit, or a long idle run in the middle of a word, discards the partial word.

Top module: `swr_cmd_rx`

## Requirements
- R1: After reset, `bright_o` is 0, `bright_vld_o` is 0 and `ack_pull_o` is 0.
- R2: A bit period spans two consecutive falling edges. The bit is 0 when the low time is at least twice the high time. The bit is 1 when the high time is at least twice the low time. An exact 2:1 ratio counts as a valid bit.
- R3: A word is 24 bits, received least significant bit first. It completes on the 25th falling edge. `bright_o` takes word bits 8..0, with bit 8 as the MSB. `bright_vld_o` rises on the 4th rising clock edge after that last falling edge appears on `line_i`.
- R4: A word whose bits 23..16 differ from 0x8F produces no strobe and leaves `bright_o` unchanged.
- R5: A bit whose low and high times are in neither 2:1 band is ambiguous. It discards the word, so no strobe and no acknowledge follow.
- R6: A single low or high run of IDLE_CYC cycles inside a word discards the bits collected so far. The next word is then received normally from its first bit.
- R7: When an accepted word has bit 10 set, `ack_pull_o` rises ACK_DLY_CYC cycles after the strobe rises. It stays high for exactly ACK_LEN_CYC cycles.
- R8: `ack_pull_o` stays low after an accepted word with bit 10 clear, and after a rejected word.
- R9: Reserved bits 15..11 and bit 9 do not affect acceptance, `bright_o` or the acknowledge.
- R10: `bright_vld_o` is a single-cycle pulse. `bright_o` changes only in a cycle where `bright_vld_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Command wire as seen at the pin, asynchronous |
| ack_pull_o | output | 1 | Enable for the open-drain pull-down on the wire |
| bright_o | output | 9 | Last accepted brightness code |
| bright_vld_o | output | 1 | One-cycle strobe on each accepted word |

## Verification
Most wrong internal states show up at the strobe within one word. A bit counter that slips by one moves the address into the wrong place, so the whole word is rejected and the strobe never comes. A swapped or off-by-one ratio comparison flips a brightness bit, and the boundary words built from exact 2:1 periods expose it. A stale frame position after an idle abort corrupts the following word, so the strobe of the next word is missing or carries the wrong code. Errors in the acknowledge timer show as a shifted rise or fall of `ack_pull_o`, measured to the cycle against the strobe.

// File: rtl/swr_pkg.sv
package swr_pkg;
    localparam int          WORD_W   = 24;
    localparam int          BRI_W    = 9;
    localparam int          ACKF_POS = 10;
    localparam logic [7:0]  DEV_ADDR = 8'h8F;

    typedef enum logic [1:0] {
        ACK_IDLE,
        ACK_WAIT,
        ACK_PULL
    } ack_st_e;
endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/swr_bit_meter.sv
module swr_bit_meter #(
    parameter int IDLE_CYC = 120000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    output logic bit_stb_o,
    output logic bit_val_o,
    output logic bit_bad_o,
    output logic tmo_o
);
    localparam int             CW  = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0]  LIM = CW'(IDLE_CYC);

    typedef struct packed {
        logic          prev;
        logic          armed;
        logic [CW-1:0] lo;
        logic [CW-1:0] hi;
        logic          stb;
        logic          val;
        logic          bad;
        logic          tmo;
    } meter_t;

    meter_t s_d, s_q;
    logic   fall;
    logic   is_zero, is_one;

    always_comb begin
        s_d      = s_q;
        s_d.prev = line_s;
        s_d.stb  = 1'b0;
        s_d.val  = 1'b0;
        s_d.bad  = 1'b0;
        s_d.tmo  = 1'b0;
        fall     = s_q.prev & ~line_s;
        is_zero  = {1'b0, s_q.lo} >= {s_q.hi, 1'b0};
        is_one   = {1'b0, s_q.hi} >= {s_q.lo, 1'b0};
        if (fall) begin
            if (s_q.armed) begin
                s_d.stb = 1'b1;
                s_d.val = is_one;
                s_d.bad = !is_zero && !is_one;
            end
            s_d.armed = 1'b1;
            s_d.lo    = CW'(1);
            s_d.hi    = '0;
        end else begin
            if (!line_s) begin
                if (s_q.lo != LIM) s_d.lo = s_q.lo + CW'(1);
            end else begin
                if (s_q.hi != LIM) s_d.hi = s_q.hi + CW'(1);
            end
            if (s_q.armed && (s_q.lo == LIM || s_q.hi == LIM)) begin
                s_d.armed = 1'b0;
                s_d.tmo   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_stb_o = s_q.stb;
    assign bit_val_o = s_q.val;
    assign bit_bad_o = s_q.bad;
    assign tmo_o     = s_q.tmo;

    // R6: a bit is only reported for a period opened by an armed edge
    p_bit_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stb |-> $past(s_q.armed));

    // R5: a classified bit and an idle abort never coincide
    p_bit_tmo_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.stb && s_q.tmo));
endmodule

// File: rtl/swr_frame_ctl.sv
module swr_frame_ctl
    import swr_pkg::*;
#(
    parameter int ACK_DLY_CYC = 25000,
    parameter int ACK_LEN_CYC = 64000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             bit_val,
    input  logic             bit_bad,
    input  logic             tmo,
    output logic [BRI_W-1:0] bright_o,
    output logic             bright_vld_o,
    output logic             ack_pull_o
);
    localparam int AMAX = (ACK_DLY_CYC > ACK_LEN_CYC) ? ACK_DLY_CYC : ACK_LEN_CYC;
    localparam int AW   = $clog2(AMAX + 1);
    localparam int NW   = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [NW-1:0]     cnt;
        logic [WORD_W-1:0] sh;
        logic [BRI_W-1:0]  bri;
        logic              vld;
        ack_st_e           ast;
        logic [AW-1:0]     acnt;
    } frame_t;

    frame_t            s_d, s_q;
    logic [WORD_W-1:0] word;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        word    = {bit_val, s_q.sh[WORD_W-1:1]};

        case (s_q.ast)
            ACK_WAIT: begin
                if (s_q.acnt == AW'(ACK_DLY_CYC - 1)) begin
                    s_d.ast  = ACK_PULL;
                    s_d.acnt = '0;
                end else begin
                    s_d.acnt = s_q.acnt + AW'(1);
                end
            end
            ACK_PULL: begin
                if (s_q.acnt == AW'(ACK_LEN_CYC - 1)) begin
                    s_d.ast  = ACK_IDLE;
                    s_d.acnt = '0;
                end else begin
                    s_d.acnt = s_q.acnt + AW'(1);
                end
            end
            default: s_d.acnt = '0;
        endcase

        if (tmo) begin
            s_d.cnt = '0;
        end else if (bit_stb) begin
            if (bit_bad) begin
                s_d.cnt = '0;
            end else begin
                s_d.sh = word;
                if (s_q.cnt == NW'(WORD_W - 1)) begin
                    s_d.cnt = '0;
                    if (word[WORD_W-1 -: 8] == DEV_ADDR) begin
                        s_d.bri = word[BRI_W-1:0];
                        s_d.vld = 1'b1;
                        if (word[ACKF_POS]) begin
                            s_d.ast  = ACK_WAIT;
                            s_d.acnt = '0;
                        end
                    end
                end else begin
                    s_d.cnt = s_q.cnt + NW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.ast <= ACK_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign bright_o     = s_q.bri;
    assign bright_vld_o = s_q.vld;
    assign ack_pull_o   = (s_q.ast == ACK_PULL);

    // R10: strobe lasts one cycle
    p_vld_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.vld |=> !s_q.vld);

    // R10: brightness holds except in a strobe cycle
    p_bright_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.vld |-> $stable(s_q.bri));

    // R3: bit position never passes the last bit of a word
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= NW'(WORD_W - 1));

    // R7: the pull-down only starts at the end of a delay phase
    p_pull_after_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_pull_o) |-> $past(s_q.ast) == ACK_WAIT);
endmodule

// File: rtl/swr_cmd_rx.sv
module swr_cmd_rx #(
    parameter int IDLE_CYC    = 120000,
    parameter int ACK_DLY_CYC = 25000,
    parameter int ACK_LEN_CYC = 64000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    output logic       ack_pull_o,
    output logic [8:0] bright_o,
    output logic       bright_vld_o
);
    logic line_s;
    logic bit_stb, bit_val, bit_bad, tmo;

    swr_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_i),
        .dout (line_s)
    );

    swr_bit_meter #(.IDLE_CYC(IDLE_CYC)) meter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_s   (line_s),
        .bit_stb_o(bit_stb),
        .bit_val_o(bit_val),
        .bit_bad_o(bit_bad),
        .tmo_o    (tmo)
    );

    swr_frame_ctl #(
        .ACK_DLY_CYC(ACK_DLY_CYC),
        .ACK_LEN_CYC(ACK_LEN_CYC)
    ) frame_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .bit_val     (bit_val),
        .bit_bad     (bit_bad),
        .tmo         (tmo),
        .bright_o    (bright_o),
        .bright_vld_o(bright_vld_o),
        .ack_pull_o  (ack_pull_o)
    );
endmodule

// File: tb/swr_cmd_rx_tb.sv
`timescale 1ns/1ps
module swr_cmd_rx_tb_top;
    localparam int IDLE = 100;
    localparam int DLY  = 40;
    localparam int LEN  = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv = 1'b1;
    logic line_i;
    logic ack_pull;
    logic [8:0] bright;
    logic bright_vld;

    always #2 clk = ~clk;
    assign line_i = drv & ~ack_pull;

    swr_cmd_rx #(.IDLE_CYC(IDLE), .ACK_DLY_CYC(DLY), .ACK_LEN_CYC(LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_i(line_i),
        .ack_pull_o(ack_pull), .bright_o(bright), .bright_vld_o(bright_vld)
    );

    int checks = 0, errors = 0;
    int cyc = 0;
    int vld_cnt = 0, vld_cyc = 0, vld_long = 0;
    int pull_cnt = 0, pull_rise = 0, pull_fall = 0;
    logic vld_prev = 1'b0, pull_prev = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n) begin
            if (bright_vld) begin
                vld_cnt++;
                vld_cyc = cyc;
                if (vld_prev) vld_long++;
            end
            if (ack_pull && !pull_prev) begin
                pull_cnt++;
                pull_rise = cyc;
            end
            if (!ack_pull && pull_prev) pull_fall = cyc;
            vld_prev  = bright_vld;
            pull_prev = ack_pull;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // lo/hi in cycles; odd_idx selects one bit with special timing
    task automatic send_word(input logic [23:0] w, input int nbits,
                             input int odd_idx, input int odd_lo, input int odd_hi,
                             output int t_last);
        @(negedge clk);
        drv = 1'b1;
        repeat (150) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            int lo, hi;
            lo = w[i] ? 10 : 20;
            hi = w[i] ? 20 : 10;
            if (i == odd_idx) begin
                lo = odd_lo;
                hi = odd_hi;
            end
            drv = 1'b0;
            repeat (lo) @(negedge clk);
            drv = 1'b1;
            repeat (hi) @(negedge clk);
        end
        t_last = cyc;
        if (nbits == 24) begin
            drv = 1'b0;
            repeat (70) @(negedge clk);
            drv = 1'b1;
            repeat (80) @(negedge clk);
        end else begin
            repeat (150) @(negedge clk);
        end
    endtask

    task automatic test_reset();
        chk("R1 bright", int'(bright), 0);
        chk("R1 vld", int'(bright_vld), 0);
        chk("R1 pull", int'(ack_pull), 0);
    endtask

    task automatic test_ack_word();
        int t, v0, p0;
        v0 = vld_cnt; p0 = pull_cnt;
        send_word({8'h8F, 16'h0400 | 16'h01A5}, 24, -1, 0, 0, t);
        chk("R3 strobe count", vld_cnt - v0, 1);
        chk("R3 bright", int'(bright), 'h1A5);
        chk("R3 strobe latency", vld_cyc - t, 4);
        chk("R7 pull count", pull_cnt - p0, 1);
        chk("R7 pull delay", pull_rise - vld_cyc, DLY);
        chk("R7 pull length", pull_fall - pull_rise, LEN);
    endtask

    task automatic test_no_ack();
        int t, v0, p0;
        v0 = vld_cnt; p0 = pull_cnt;
        send_word({8'h8F, 16'h0033}, 24, -1, 0, 0, t);
        chk("R2 strobe count", vld_cnt - v0, 1);
        chk("R2 bright", int'(bright), 'h033);
        chk("R8 no pull", pull_cnt - p0, 0);
    endtask

    task automatic test_bad_addr();
        int t, v0, p0;
        v0 = vld_cnt; p0 = pull_cnt;
        send_word({8'h8E, 16'h04FF}, 24, -1, 0, 0, t);
        send_word({8'hF8, 16'h04FF}, 24, -1, 0, 0, t);
        chk("R4 no strobe", vld_cnt - v0, 0);
        chk("R4 bright kept", int'(bright), 'h033);
        chk("R8 no pull on reject", pull_cnt - p0, 0);
    endtask

    task automatic test_reserved();
        int t, v0, p0;
        v0 = vld_cnt; p0 = pull_cnt;
        send_word({8'h8F, 16'hFA00 | 16'h0155}, 24, -1, 0, 0, t);
        chk("R9 strobe count", vld_cnt - v0, 1);
        chk("R9 bright", int'(bright), 'h155);
        chk("R9 no pull", pull_cnt - p0, 0);
    endtask

    task automatic test_ratio_edges();
        int t, v0, p0;
        v0 = vld_cnt; p0 = pull_cnt;
        // exact 2:1 zero (40/20) on bit 1, exact 2:1 one (7/14) on bit 0
        send_word({8'h8F, 16'h0001}, 24, 1, 40, 20, t);
        chk("R2 exact-ratio zero", int'(bright), 'h001);
        send_word({8'h8F, 16'h0000}, 24, 0, 7, 14, t);
        chk("R2 exact-ratio one", int'(bright), 'h001);
        chk("R2 both strobes", vld_cnt - v0, 2);
        v0 = vld_cnt;
        send_word({8'h8F, 16'h04AA}, 24, 5, 15, 15, t);
        send_word({8'h8F, 16'h04AA}, 24, 3, 19, 10, t);
        chk("R5 ambiguous drops", vld_cnt - v0, 0);
        chk("R5 bright kept", int'(bright), 'h001);
        chk("R5 no pull", pull_cnt - p0, 0);
    endtask

    task automatic test_timeout();
        int t, v0;
        v0 = vld_cnt;
        send_word({8'h8F, 16'h00C3}, 10, -1, 0, 0, t);
        chk("R6 no strobe after abort", vld_cnt - v0, 0);
        send_word({8'h8F, 16'h00C3}, 24, -1, 0, 0, t);
        chk("R6 next word strobe", vld_cnt - v0, 1);
        chk("R6 next word bright", int'(bright), 'h0C3);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        test_ack_word();
        test_no_ack();
        test_bad_addr();
        test_reserved();
        test_ratio_edges();
        test_timeout();
        chk("R10 single-cycle strobe", vld_long, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule